// File: doc/BRIEF.md
# Reversible-Gate Adder/Subtractor

This block adds or subtracts two N-bit unsigned operands. Its datapath is a network of reversible primitives only: a controlled-NOT (copies its control and XORs it into its target), a three-input XOR/AND gate (passes `a`, gives `a^b` and `(a&b)^c`), and a controlled swap (exchanges its two data lines when the control is 1). A single `mode` input picks the operation. With `mode` low the result is the sum. With `mode` high the result is the two's-complement difference `a + ~b + 1`.

Each bit stage has the same shape. First it conditionally inverts its `b` bit with a controlled-NOT driven by the mode line. Then it forms propagate and generate with one XOR/AND gate, and the result bit and the `P&C` term with a second one. A controlled swap, fed constant 1, turns generate and `P&C` into the outgoing carry. Each stage's controlled-NOT passes the mode line on to the next stage. One extra controlled-NOT at bit 0, with a constant-0 target, seeds both the carry-in and bit 0's mode line. As a result only one mode copy is left over as garbage.

Every leftover gate output is brought out on a garbage bus. The gate network is combinational. The result, carry and garbage bus are registered once on the clock, with a synchronous active-high reset.

Top module: `rsub_addsub`

## Requirements
- R1: With `mode`=0, `f` equals `(a + b) mod 2^N`.
- R2: With `mode`=1, `f` equals `(a - b) mod 2^N`, formed as `a + ~b + 1`.
- R3: With `mode`=0, `cout` is the unsigned carry out of `a + b`.
- R4: With `mode`=1, `cout` is 1 exactly when `a >= b`, so a 1 means no borrow occurred.
- R5: The garbage bus is 4N+1 bits wide. Bit 4N holds a copy of `mode` taken from the last stage's mode pass-through.
- R6: For each stage i, let `m` be the mode value, `Ci` the carry into stage i, and `C0 = m`. Then garbage bit 4i is `a[i]`, bit 4i+1 is `a[i]^b[i]^m`, bit 4i+2 is `a[i]&(b[i]^m)`, and bit 4i+3 is `~bit(4i+2) | (bit(4i+1) & Ci)`.
- R7: Outputs are registered. Inputs present at a rising clock edge show up on `f`, `cout` and `garb` after that edge, not before.
- R8: When `rst` is high at a rising edge, `f`, `cout` and `garb` become all zeros.
- R9: The cost figures in the package are 3N+1 constant inputs, 4N+1 garbage lines and a cost of 14N+1 (unit costs: controlled-NOT 1, XOR/AND gate 4, controlled swap 5). At N=8 this gives 33 garbage lines and a cost of 113.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = add, 1 = subtract |
| a | input | N | First operand |
| b | input | N | Second operand |
| f | output | N | Registered sum or difference |
| cout | output | 1 | Registered final carry (no-borrow flag when subtracting) |
| garb | output | 4N+1 | Registered leftover gate outputs |

## Verification
The bench targets the cases where the carry wraps:
- all-ones plus one;
- zero minus one;
- equal operands under subtraction.

A design that forgot the +1 seed would be off by one on every difference. A design that inverted `b` in add mode would fail the plain sums. A design that lost the mode copy along the chain would break only the upper bits, and the exhaustive 4-bit sweep exposes that. The garbage bus is checked bit by bit, so a miswired swap gate or a reordered field shows up even when `f` is correct. Checks of the reset clear and of the one-cycle latency catch a design that drops the output register.

// File: rtl/rsub_pkg.sv
package rsub_pkg;

  localparam int unsigned COST_CNOT  = 1;
  localparam int unsigned COST_XAND  = 4;
  localparam int unsigned COST_SWAP  = 5;

  // constants per stage: two XOR/AND zeros, one swap one; plus seed zero
  function automatic int unsigned const_count(int unsigned n);
    return 3 * n + 1;
  endfunction

  // four leftover lines per stage plus the final mode copy
  function automatic int unsigned garbage_count(int unsigned n);
    return 4 * n + 1;
  endfunction

  function automatic int unsigned gate_cost(int unsigned n);
    return n * (COST_CNOT + 2 * COST_XAND + COST_SWAP) + COST_CNOT;
  endfunction

endpackage

// File: rtl/rsub_cnot.sv
module rsub_cnot (
  input  logic ctl,
  input  logic tgt,
  output logic ctl_o,
  output logic tgt_o
);
  assign ctl_o = ctl;
  assign tgt_o = ctl ^ tgt;
endmodule

// File: rtl/rsub_xand.sv
module rsub_xand (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic x_o,
  output logic xy_o,
  output logic and_o
);
  assign x_o   = x;
  assign xy_o  = x ^ y;
  assign and_o = (x & y) ^ z;
endmodule

// File: rtl/rsub_swap.sv
module rsub_swap (
  input  logic sel,
  input  logic d0,
  input  logic d1,
  output logic sel_o,
  output logic q0,
  output logic q1
);
  assign sel_o = sel;
  assign q0    = sel ? d1 : d0;
  assign q1    = sel ? d0 : d1;

  // the swap conserves the number of ones
  always_comb begin
    if (!$isunknown({sel, d0, d1}))
      p_swap_conserve_r6: assert ($countones({sel, d0, d1}) == $countones({sel_o, q0, q1}));
  end
endmodule

// File: rtl/rsub_stage.sv
module rsub_stage (
  input  logic       m_in,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       c_in,
  output logic       m_out,
  output logic       f_bit,
  output logic       c_out,
  output logic [3:0] junk
);
  logic bm, a_pass, prop, gen, prop_pass, pc, gen_pass, swap_rest;

  rsub_cnot u_inv (.ctl(m_in), .tgt(b_bit), .ctl_o(m_out), .tgt_o(bm));

  rsub_xand u_pg (.x(a_bit), .y(bm), .z(1'b0),
                  .x_o(a_pass), .xy_o(prop), .and_o(gen));

  rsub_xand u_sum (.x(prop), .y(c_in), .z(1'b0),
                   .x_o(prop_pass), .xy_o(f_bit), .and_o(pc));

  // sel=gen, d0=pc, d1=1: q0 = gen | pc, q1 = ~gen | pc
  rsub_swap u_cy (.sel(gen), .d0(pc), .d1(1'b1),
                  .sel_o(gen_pass), .q0(c_out), .q1(swap_rest));

  assign junk = {swap_rest, gen_pass, prop_pass, a_pass};

  // outgoing carry is the majority of a, conditioned b and carry-in
  always_comb begin
    if (!$isunknown({a_bit, bm, c_in}))
      p_stage_major_r3: assert (c_out == ((a_bit & bm) | (a_bit & c_in) | (bm & c_in)));
  end
endmodule

// File: rtl/rsub_addsub.sv
module rsub_addsub
  import rsub_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode,
  input  logic [N-1:0]                  a,
  input  logic [N-1:0]                  b,
  output logic [N-1:0]                  f,
  output logic                          cout,
  output logic [garbage_count(N)-1:0]   garb
);
  localparam int unsigned GW = garbage_count(N);

  logic [N:0]    m_chain;
  logic [N:0]    cy;
  logic [N-1:0]  f_c;
  logic [GW-1:0] g_c;

  // seed: copy mode onto stage 0 control and onto carry-in
  rsub_cnot u_seed (.ctl(mode), .tgt(1'b0), .ctl_o(m_chain[0]), .tgt_o(cy[0]));

  for (genvar i = 0; i < N; i++) begin : g_bit
    rsub_stage u_stage (
      .m_in  (m_chain[i]),
      .a_bit (a[i]),
      .b_bit (b[i]),
      .c_in  (cy[i]),
      .m_out (m_chain[i+1]),
      .f_bit (f_c[i]),
      .c_out (cy[i+1]),
      .junk  (g_c[4*i +: 4])
    );
  end

  assign g_c[GW-1] = m_chain[N];

  always_ff @(posedge clk) begin
    if (rst) begin
      f    <= '0;
      cout <= 1'b0;
      garb <= '0;
    end else begin
      f    <= f_c;
      cout <= cy[N];
      garb <= g_c;
    end
  end

  // reference arithmetic for the checks below
  logic [N:0] ref_add, ref_sub;
  assign ref_add = {1'b0, a} + {1'b0, b};
  assign ref_sub = {1'b0, a} + {1'b0, ~b} + {{N{1'b0}}, 1'b1};

  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (!mode) |=> (f == $past(ref_add[N-1:0])));

  p_sub_diff_r2: assert property (@(posedge clk) disable iff (rst)
    (mode) |=> (f == $past(ref_sub[N-1:0])));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode) |=> (cout == $past(ref_add[N])));

  p_sub_noborrow_r4: assert property (@(posedge clk) disable iff (rst)
    (mode) |=> (cout == $past(a >= b)));

  p_mode_copy_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (garb[GW-1] == $past(mode)));
endmodule

// File: tb/rsub_addsub_bench.sv
module rsub_addsub_bench;
  import rsub_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        m8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0, f8;
  logic        c8;
  logic [32:0] g8;

  logic        m4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0, f4;
  logic        c4;
  logic [16:0] g4;

  rsub_addsub #(.N(8)) u_rsub_addsub (
    .clk(clk), .rst(rst), .mode(m8), .a(a8), .b(b8),
    .f(f8), .cout(c8), .garb(g8));

  rsub_addsub #(.N(4)) u_rsub_addsub_n4 (
    .clk(clk), .rst(rst), .mode(m4), .a(a4), .b(b4),
    .f(f4), .cout(c4), .garb(g4));

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 field layout computed from the stated equations
  function automatic logic [63:0] exp_garb(input int n, input logic m, input logic [7:0] a, input logic [7:0] b);
    logic [63:0] r;
    logic c, bm, p, g;
    r = '0;
    c = m;
    for (int i = 0; i < n; i++) begin
      bm = b[i] ^ m;
      p  = a[i] ^ bm;
      g  = a[i] & bm;
      r[4*i]   = a[i];
      r[4*i+1] = p;
      r[4*i+2] = g;
      r[4*i+3] = ~g | (p & c);
      c = g | (p & c);
    end
    r[4*n] = m;
    return r;
  endfunction

  // {mode, a, b, cout, f}
  localparam logic [25:0] VEC [12] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'hFF, 8'h01, 1'b1, 8'h00},
    {1'b0, 8'h7F, 8'h01, 1'b0, 8'h80},
    {1'b0, 8'hA5, 8'h5A, 1'b0, 8'hFF},
    {1'b0, 8'hFF, 8'hFF, 1'b1, 8'hFE},
    {1'b0, 8'h80, 8'h80, 1'b1, 8'h00},
    {1'b1, 8'h05, 8'h03, 1'b1, 8'h02},
    {1'b1, 8'h03, 8'h05, 1'b0, 8'hFE},
    {1'b1, 8'h00, 8'h00, 1'b1, 8'h00},
    {1'b1, 8'h00, 8'h01, 1'b0, 8'hFF},
    {1'b1, 8'h80, 8'h7F, 1'b1, 8'h01},
    {1'b1, 8'hFF, 8'hFF, 1'b1, 8'h00}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(f8 == 0 && c8 == 0 && g8 == 0, "R8 reset clear", {f8, c8}, 0);

    // R9: cost accounting
    chk(gate_cost(8) == 113, "R9 cost N=8", gate_cost(8), 113);
    chk(garbage_count(8) == 33, "R9 garbage N=8", garbage_count(8), 33);
    chk(const_count(4) == 13 && gate_cost(4) == 14*4+1, "R9 constants/cost N=4", const_count(4), 13);
    chk($bits(g8) == 33, "R5 garbage width", $bits(g8), 33);

    rst = 1'b0;
    // R7: inputs not yet clocked must not show on outputs
    m8 = 1'b0; a8 = 8'h12; b8 = 8'h34;
    #1;
    chk(f8 == 8'h00, "R7 no output before edge", f8, 8'h00);
    @(negedge clk);
    chk(f8 == 8'h46, "R7 output after one edge", f8, 8'h46);

    // table walk: R1..R6
    foreach (VEC[k]) begin
      logic [63:0] eg;
      {m8, a8, b8} = VEC[k][25:9];
      @(negedge clk);
      eg = exp_garb(8, VEC[k][25], VEC[k][24:17], VEC[k][16:9]);
      chk(f8 == VEC[k][7:0], VEC[k][25] ? "R2 table diff" : "R1 table sum", f8, VEC[k][7:0]);
      chk(c8 == VEC[k][8], VEC[k][25] ? "R4 table no-borrow" : "R3 table carry", c8, VEC[k][8]);
      chk({31'b0, g8} == eg, "R6 table garbage fields", g8, eg);
    end

    // exhaustive N=4
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          logic [4:0] ex;
          logic [63:0] eg;
          m4 = m[0]; a4 = x[3:0]; b4 = y[3:0];
          @(negedge clk);
          ex = m[0] ? {(x >= y), 4'((x - y) & 15)} : 5'(x + y);
          eg = exp_garb(4, m[0], {4'b0, x[3:0]}, {4'b0, y[3:0]});
          chk(f4 == ex[3:0], m[0] ? "R2 sweep diff" : "R1 sweep sum", f4, ex[3:0]);
          chk(c4 == ex[4], m[0] ? "R4 sweep no-borrow" : "R3 sweep carry", c4, ex[4]);
          chk({47'b0, g4} == eg, "R6 R5 sweep garbage", g4, eg);
        end
      end
    end

    // random N=8
    for (int k = 0; k < 300; k++) begin
      logic [8:0] ex;
      logic [63:0] eg;
      m8 = 1'($urandom); a8 = 8'($urandom); b8 = 8'($urandom);
      @(negedge clk);
      ex = m8 ? {(a8 >= b8), 8'(a8 - b8)} : ({1'b0, a8} + {1'b0, b8});
      eg = exp_garb(8, m8, a8, b8);
      chk(f8 == ex[7:0], m8 ? "R2 random diff" : "R1 random sum", f8, ex[7:0]);
      chk(c8 == ex[8], m8 ? "R4 random no-borrow" : "R3 random carry", c8, ex[8]);
      chk({31'b0, g8} == eg, "R6 random garbage", g8, eg);
      chk(g8[32] == m8, "R5 mode copy", g8[32], m8);
    end

    // R8: reset in mid-run with nonzero inputs
    m8 = 1'b1; a8 = 8'hC3; b8 = 8'h11;
    rst = 1'b1;
    @(negedge clk);
    chk(f8 == 0 && c8 == 0 && g8 == 0, "R8 mid-run reset", {g8, c8, f8}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(f8 == 8'hB2 && c8 == 1'b1, "R2 after reset release", {c8, f8}, 9'h1B2);

    finish_run();
  end
endmodule